// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns parallel bytes into asynchronous serial frames. A byte enters through a valid/ready stream port and lands in a one-entry holding register. As soon as the frame engine is free, the byte moves into the shift register, and the holding register is free again for the next byte. The engine then drives the serial line with a low start bit, the data bits least significant first, an optional parity bit and a high stop period. Each bit lasts sixteen cycles of the transmit clock, which runs at sixteen times the bit rate.

Four settings shape the frame: word length (5 to 8 bits), parity on or off, parity sense, and stop length (1, 1.5 or 2 bit times). They are captured from static inputs when a control-load strobe is pulsed. A frame uses the settings that are held when that frame starts. Two plain status outputs report whether the holding register is empty and whether the shift register is empty.

The stream rules are as follows. `in_ready` equals the holding-empty flag. A byte is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. While `in_ready` is low, the source must keep `in_valid` and `in_data` steady. That byte waits and is taken on the first edge at which the holding register is free.

Top module: `sertx_top`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties both registers. After it, `hold_empty`, `shift_empty` and `in_ready` are 1 and `txd` is 1 (idle). The settings return to 8 data bits, parity off, one stop bit.
- R2: A frame starts with `txd` low for exactly 16 clocks. Then each data bit is driven for exactly 16 clocks, least significant bit first.
- R3: `cfg_wlen` selects the word length as 5 plus its value: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Only that many low-order bits of the byte are sent.
- R4: When `cfg_par_en` is 1, one parity bit of 16 clocks follows the data. With `cfg_par_odd` at 0, the parity bit makes the count of ones over data and parity even. With `cfg_par_odd` at 1, it makes that count odd. When `cfg_par_en` is 0, no parity bit is sent.
- R5: The stop period is high. Its length is set by `cfg_stop`: 00 gives 16 clocks, 01 gives 24 clocks, and 10 or 11 give 32 clocks.
- R6: `in_ready` is low while the holding register is full, and a byte offered then is held off. It is not lost, and it is not accepted until the register empties. When a byte is waiting, its start bit follows the previous stop period directly, with no idle clock in between.
- R7: Suppose a byte is accepted at edge E while the shifter is idle. After E, `hold_empty` is 0 and `shift_empty` is 1. After edge E+1, `hold_empty` is 1, `shift_empty` is 0 and `txd` is 0. After the last stop clock, with nothing waiting, `shift_empty` returns to 1.
- R8: The settings change only at an edge where `cfg_load` is 1. Changes on the configuration inputs without that strobe have no effect on later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, 16 times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Strobe that captures the four settings |
| cfg_wlen | input | 2 | Word length select, 5 plus this value |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_odd | input | 1 | Parity sense: 1 selects odd, 0 selects even |
| cfg_stop | input | 2 | Stop length: 00 one bit, 01 one and a half bits, 1x two bits |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | Holding register can take a byte |
| hold_empty | output | 1 | Holding register empty |
| shift_empty | output | 1 | Shift register idle |
| txd | output | 1 | Serial output, idle high |

## Verification
Results are due at these times:

- An accepted byte shows up as a full holding register one edge after acceptance.
- The start bit appears one edge after that, with `hold_empty` back high and `shift_empty` low at the same time.
- The line is then in the start state from that edge on.
- Each later field begins exactly 16 clocks after the previous one. The stop period lasts 16, 24 or 32 clocks.
- `shift_empty` returns one edge after the last stop clock.

How the checks keep to that timing:

- All outputs are sampled at the falling edge, so each sample sees the values settled after the preceding rising edge.
- The driver checks the two flags at the first and second falling edges after acceptance.
- The monitor aligns on the first low sample of a frame. It then counts every sample of every field against a frame that the driver queued in advance.
- For frames flagged as back-to-back, it checks that no idle sample separates them. For a final frame, it checks `shift_empty` at the sample right after the stop period.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    TX_IDLE  = 3'd0,
    TX_START = 3'd1,
    TX_DATA  = 3'd2,
    TX_PAR   = 3'd3,
    TX_STOP  = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_odd;
    logic [1:0] stop;
  } tx_cfg_t;

  localparam tx_cfg_t CFG_RESET = '{wlen: 2'b11, par_en: 1'b0, par_odd: 1'b0, stop: 2'b00};

endpackage

// File: rtl/sertx_cfg_reg.sv
module sertx_cfg_reg
  import sertx_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    load_i,
  input  tx_cfg_t cfg_i,
  output tx_cfg_t cfg_o
);

  tx_cfg_t cfg_q;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= CFG_RESET;
    else if (load_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;

  // Settings move only on the strobe.
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(cfg_q));

endmodule

// File: rtl/sertx_hold_buf.sv
module sertx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              take_i,
  output logic              in_ready_o,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign in_ready_o = !full_q;
  assign accept     = in_valid_i && !full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (take_i) begin
      full_q <= 1'b0;
    end else if (accept) begin
      full_q <= 1'b1;
      data_q <= in_data_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  // A waiting byte is neither lost nor overwritten.
  assert_hold_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    (full_q && !take_i) |=> (full_q && $stable(data_q)));

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              avail_i,
  input  logic [DATA_W-1:0] hold_data_i,
  input  tx_cfg_t           cfg_i,
  output logic              take_o,
  output logic              txd_o,
  output logic              idle_o
);

  localparam int CNT_W   = $clog2(2 * OVERSAMPLE);
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int MIN_LEN = DATA_W - 3;

  tx_state_e         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  len_m1_q;
  logic [CNT_W-1:0]  stop_m1_q;
  logic              par_en_q;
  logic              par_bit_q;
  logic [DATA_W-1:0] sh_q;
  logic              txd_q;

  logic [IDX_W-1:0]  len_m1_n;
  logic [DATA_W-1:0] mask_n;
  logic              par_bit_n;
  logic [CNT_W-1:0]  stop_m1_n;
  logic              bit_end;
  logic              frame_end;

  // Frame settings computed from the live configuration at frame start.
  always_comb begin
    len_m1_n = IDX_W'(MIN_LEN - 1) + IDX_W'(cfg_i.wlen);
    for (int i = 0; i < DATA_W; i++) begin
      mask_n[i] = (IDX_W'(i) <= len_m1_n);
    end
    par_bit_n = (^(hold_data_i & mask_n)) ^ cfg_i.par_odd;
    case (cfg_i.stop)
      2'b00:   stop_m1_n = CNT_W'(OVERSAMPLE - 1);
      2'b01:   stop_m1_n = CNT_W'(OVERSAMPLE + OVERSAMPLE / 2 - 1);
      default: stop_m1_n = CNT_W'(2 * OVERSAMPLE - 1);
    endcase
  end

  assign bit_end   = (cnt_q == CNT_W'(OVERSAMPLE - 1));
  assign frame_end = (state_q == TX_STOP) && (cnt_q == stop_m1_q);
  assign take_o    = avail_i && ((state_q == TX_IDLE) || frame_end);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= TX_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      len_m1_q  <= '0;
      stop_m1_q <= '0;
      par_en_q  <= 1'b0;
      par_bit_q <= 1'b0;
      sh_q      <= '0;
      txd_q     <= 1'b1;
    end else if (take_o) begin
      state_q   <= TX_START;
      cnt_q     <= '0;
      idx_q     <= '0;
      len_m1_q  <= len_m1_n;
      stop_m1_q <= stop_m1_n;
      par_en_q  <= cfg_i.par_en;
      par_bit_q <= par_bit_n;
      sh_q      <= hold_data_i;
      txd_q     <= 1'b0;
    end else begin
      unique case (state_q)
        TX_START: begin
          if (bit_end) begin
            state_q <= TX_DATA;
            cnt_q   <= '0;
            txd_q   <= sh_q[0];
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        TX_DATA: begin
          if (bit_end) begin
            cnt_q <= '0;
            if (idx_q == len_m1_q) begin
              if (par_en_q) begin
                state_q <= TX_PAR;
                txd_q   <= par_bit_q;
              end else begin
                state_q <= TX_STOP;
                txd_q   <= 1'b1;
              end
            end else begin
              idx_q <= idx_q + IDX_W'(1);
              sh_q  <= sh_q >> 1;
              txd_q <= sh_q[1];
            end
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        TX_PAR: begin
          if (bit_end) begin
            state_q <= TX_STOP;
            cnt_q   <= '0;
            txd_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        TX_STOP: begin
          if (frame_end) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            txd_q   <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: begin
          state_q <= TX_IDLE;
          txd_q   <= 1'b1;
        end
      endcase
    end
  end

  assign txd_o  = txd_q;
  assign idle_o = (state_q == TX_IDLE);

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (rst)
    idle_o |-> txd_o);

  assert_start_after_take_R7: assert property (@(posedge clk) disable iff (rst)
    take_o |=> (!txd_o && !idle_o));

  assert_stop_high_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == TX_STOP) |-> txd_o);

  assert_bit_count_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == TX_DATA) |-> (idx_q <= len_m1_q));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic [1:0]        cfg_stop,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              txd
);

  tx_cfg_t           cfg_in;
  tx_cfg_t           cfg_cur;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              sh_idle;

  assign cfg_in = '{wlen: cfg_wlen, par_en: cfg_par_en, par_odd: cfg_par_odd, stop: cfg_stop};

  sertx_cfg_reg u_cfg (
    .clk    (clk),
    .rst    (rst),
    .load_i (cfg_load),
    .cfg_i  (cfg_in),
    .cfg_o  (cfg_cur)
  );

  sertx_hold_buf #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .in_valid_i (in_valid),
    .in_data_i  (in_data),
    .take_i     (take),
    .in_ready_o (in_ready),
    .full_o     (hold_full),
    .data_o     (hold_data)
  );

  sertx_shifter #(.DATA_W(DATA_W), .OVERSAMPLE(OVERSAMPLE)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .avail_i     (hold_full),
    .hold_data_i (hold_data),
    .cfg_i       (cfg_cur),
    .take_o      (take),
    .txd_o       (txd),
    .idle_o      (sh_idle)
  );

  assign hold_empty  = !hold_full;
  assign shift_empty = sh_idle;

  assert_transfer_flags_R7: assert property (@(posedge clk) disable iff (rst)
    take |=> (hold_empty && !shift_empty));

endmodule

// File: tb/sertx_top_tb_top.sv
module sertx_top_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_load = 1'b0;
  logic [1:0] cfg_wlen = 2'b11;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_odd = 1'b0;
  logic [1:0] cfg_stop = 2'b00;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready, hold_empty, shift_empty, txd;

  always #4 clk = ~clk;

  sertx_top dut_i (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_wlen(cfg_wlen),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .hold_empty(hold_empty), .shift_empty(shift_empty), .txd(txd)
  );

  typedef struct {
    logic [7:0] data;
    int         len;
    bit         par_en;
    bit         par_odd;
    int         stop_clks;
    bit         b2b;
    bit         last;
  } frame_t;

  frame_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit mon_busy = 0;
  bit done = 0;

  // Bench copy of the loaded settings
  int  sh_len = 8;
  bit  sh_pe = 0, sh_po = 0;
  int  sh_stop = 16;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [1:0] w, input bit pe, input bit po, input logic [1:0] st);
    @(negedge clk);
    cfg_wlen = w; cfg_par_en = pe; cfg_par_odd = po; cfg_stop = st;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    sh_len = 5 + int'(w); sh_pe = pe; sh_po = po;
    sh_stop = (st == 2'b00) ? 16 : (st == 2'b01) ? 24 : 32;
  endtask

  task automatic send(input logic [7:0] d, input bit b2b, input bit last, input bit timed);
    frame_t f;
    f.data = d; f.len = sh_len; f.par_en = sh_pe; f.par_odd = sh_po;
    f.stop_clks = sh_stop; f.b2b = b2b; f.last = last;
    exp_q.push_back(f);
    @(negedge clk);
    in_valid = 1'b1; in_data = d;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (timed) begin
      chk(!hold_empty, "R7", "hold_empty one edge after accept", hold_empty, 0);
      chk(shift_empty, "R7", "shift_empty one edge after accept", shift_empty, 1);
      @(negedge clk);
      chk(hold_empty, "R7", "hold_empty after transfer", hold_empty, 1);
      chk(!shift_empty, "R7", "shift_empty after transfer", shift_empty, 0);
      chk(txd == 1'b0, "R7", "start bit after transfer", txd, 0);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    while (exp_q.size() != 0 || mon_busy) @(negedge clk);
  endtask

  // Monitor: pops expected frames and compares the serial line
  initial begin
    int gap = 0;
    forever begin
      @(negedge clk);
      if (rst || txd !== 1'b0) begin
        gap++;
      end else if (exp_q.size() == 0) begin
        chk(0, "R2", "unexpected start bit", 0, 1);
        while (txd !== 1'b1) @(negedge clk);
      end else begin
        frame_t f;
        bit ok;
        logic [7:0] rx;
        logic b;
        int pc;
        mon_busy = 1;
        f = exp_q.pop_front();
        if (f.b2b) chk(gap == 0, "R6", "idle gap between queued frames", gap, 0);
        ok = 1;
        for (int i = 1; i < 16; i++) begin
          @(negedge clk);
          if (txd !== 1'b0) ok = 0;
        end
        chk(ok, "R2", "start bit low for 16 clocks", ok, 1);
        ok = 1; rx = 8'h00; pc = 0;
        for (int k = 0; k < f.len; k++) begin
          @(negedge clk);
          b = txd;
          for (int i = 1; i < 16; i++) begin
            @(negedge clk);
            if (txd !== b) ok = 0;
          end
          rx[k] = b;
          if (b) pc++;
        end
        chk(ok, "R2", "data bits held 16 clocks", ok, 1);
        chk(rx == (f.data & 8'((1 << f.len) - 1)), "R3", "data word lsb first", rx,
            f.data & 8'((1 << f.len) - 1));
        if (f.par_en) begin
          logic pexp;
          pexp = ((pc % 2) == 1) ^ f.par_odd;
          ok = 1;
          for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (txd !== pexp) ok = 0;
          end
          chk(ok, "R4", "parity bit value", txd, pexp);
        end
        ok = 1;
        for (int i = 0; i < f.stop_clks; i++) begin
          @(negedge clk);
          if (txd !== 1'b1) ok = 0;
        end
        chk(ok, "R5", "stop period high", ok, 1);
        if (f.last) begin
          @(negedge clk);
          chk(shift_empty === 1'b1, "R7", "shift_empty right after stop", shift_empty, 1);
          chk(txd === 1'b1, "R5", "line idle after stop", txd, 1);
          if (txd === 1'b1) gap = 1; else gap = 0;
        end else begin
          gap = 0;
        end
        mon_busy = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(hold_empty, "R1", "hold_empty after reset", hold_empty, 1);
    chk(shift_empty, "R1", "shift_empty after reset", shift_empty, 1);
    chk(in_ready, "R1", "in_ready after reset", in_ready, 1);
    chk(txd, "R1", "txd idle after reset", txd, 1);

    // Default settings after reset: 8 bits, no parity, one stop bit (R1)
    send(8'hA5, 0, 1, 1);
    drain();

    // 5 bits, even parity, two stop bits
    load_cfg(2'b00, 1, 0, 2'b10);
    send(8'h3B, 0, 1, 0);
    drain();

    // 6 bits, odd parity, 1.5 stop bits
    load_cfg(2'b01, 1, 1, 2'b01);
    send(8'h2D, 0, 1, 0);
    drain();

    // 7 bits, even parity, one stop bit
    load_cfg(2'b10, 1, 0, 2'b00);
    send(8'h7F, 0, 1, 0);
    drain();

    // R8: inputs change without strobe, frame keeps 7 bits even parity one stop
    @(negedge clk);
    cfg_wlen = 2'b00; cfg_par_en = 1'b1; cfg_par_odd = 1'b1; cfg_stop = 2'b11;
    send(8'h96, 0, 1, 0);
    drain();

    // R6: back-pressure with three queued bytes, 8 bits odd parity 1.5 stop
    load_cfg(2'b11, 1, 1, 2'b01);
    send(8'h01, 0, 0, 0);
    send(8'h80, 1, 0, 0);
    chk(!in_ready, "R6", "in_ready low while byte waits", in_ready, 0);
    send(8'hFF, 1, 1, 0);
    drain();

    // 8 bits, no parity, two stop bits, two bytes back to back
    load_cfg(2'b11, 0, 0, 2'b11);
    send(8'h5A, 0, 0, 0);
    send(8'hC3, 1, 1, 0);
    drain();

    repeat (4) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule